// File: doc/BRIEF.md
# Return-to-Zero Serial Word Receiver

This block takes one self-clocked bipolar serial stream, presented as two digital line levels from an external comparator, and turns each received word into a parallel value that a host reads over a 16-bit bus. The line level `ln_pos` is high while the line carries a positive pulse (a one) and `ln_neg` is high for a negative pulse (a zero). Both low means the line has returned to null between bits. The receiver runs from a clock at ten times the bit rate and frames every word from the line activity alone, so any bit rate up to the clock limit works without a strobe or a link to transmit timing.

A bit is taken once its pulse has been seen for a minimum run of samples. Bits fill the word from bit 0 upward until the selected length (32 or 25 bits) is reached. The word is then latched together with a parity status, and a ready flag is raised. The host reads the word as two 16-bit halves: `half_sel` chooses the half and `rd_en` gates it onto the bus. A null that lasts too long in the middle of a word throws the partial word away.

Top module: `rz_word_rx`

## Requirements
- R1: A one is taken when `ln_pos`=1 and `ln_neg`=0 for at least 3 consecutive samples, and a zero when `ln_neg`=1 and `ln_pos`=0 for at least 3 samples. Each pulse gives exactly one bit. Shorter pulses, and samples with both inputs high, add no bit.
- R2: The first bit received lands in word bit 0. Half 0 (`half_sel`=0) carries word bits 7..0 on bus bits 7..0, the parity status on bus bit 8, and word bits 14..8 on bus bits 15..9. Half 1 (`half_sel`=1) carries word bits 30..15 on bus bits 15..0.
- R3: With `len_full`=1 a word is complete after 32 bits. Bit 31 (the word's parity bit) is not placed on the bus.
- R4: With `len_full`=0 a word is complete after 25 bits. Bit 24 is the parity bit, and every bus position for word bits 24 and above reads 0.
- R5: The parity status is 1 when the count of ones over all received bits of the word, including its parity bit, is even, and 0 when it is odd.
- R6: `rdy` rises once the last bit of a word has been taken. It stays high until the host reads half 1.
- R7: A clock edge with `rd_en`=1 and `half_sel`=1 clears `rdy`. Reading half 0 leaves `rdy` set.
- R8: A word that completes before the previous one is read replaces the latched word, and `rdy` stays 1.
- R9: A null lasting 20 samples (2 bit times) in the middle of a word discards the bits taken so far. The next pulse then starts a new word.
- R10: With `rd_en`=0, `bus_q` is 0.
- R11: A synchronous active-high `rst` clears `rdy`, the latched word, the parity status and any partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, ten times the bit rate |
| rst | input | 1 | Synchronous active-high master reset |
| ln_pos | input | 1 | Line positive-level indication |
| ln_neg | input | 1 | Line negative-level indication |
| len_full | input | 1 | 1: 32-bit words, 0: 25-bit words |
| half_sel | input | 1 | 0: read half 0, 1: read half 1 |
| rd_en | input | 1 | Gates the selected half onto `bus_q` |
| rdy | output | 1 | A latched word waits to be read |
| bus_q | output | 16 | Host data bus |

## Verification
The hardest situation to reach from the ports is a partial word being discarded by a long null. If discard is broken, nothing shows until a later word arrives misaligned. The bench sends a partial word, holds the line at null past the limit, then sends a full word and checks that every bit of it lands in place. Pulse timing is also drawn at random within legal bounds. Sub-threshold pulses and both-high samples are placed inside the null between bits, so a receiver that counts the wrong edges produces a wrong word instead of passing unseen.

// File: rtl/rzx_pkg.sv
package rzx_pkg;
   // decoded line level: {pos, neg}
   typedef enum logic [1:0] {
      LV_NULL = 2'b00,
      LV_ZERO = 2'b01,
      LV_ONE  = 2'b10,
      LV_BAD  = 2'b11
   } lvl_t;

   function automatic logic is_data(lvl_t l);
      return (l == LV_ONE) || (l == LV_ZERO);
   endfunction
endpackage

// File: rtl/rzx_sampler.sv
module rzx_sampler
   import rzx_pkg::*;
#(
   parameter int OVS      = 10,
   parameter int MIN_RUN  = 3,
   parameter int GAP_BITS = 2,
   parameter int SYNC     = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic line_p,
   input  logic line_n,
   output logic bit_stb,
   output logic bit_val,
   output logic gap_stb
);
   localparam int GAP_LIM = GAP_BITS * OVS;
   localparam int CW      = $clog2(GAP_LIM + 1);
   localparam logic [CW-1:0] RUN_K = CW'(MIN_RUN);
   localparam logic [CW-1:0] GAP_K = CW'(GAP_LIM);

   logic [1:0]    raw;
   logic [1:0]    lvl_raw;
   lvl_t          lvl_in, lvl_q;
   logic [CW-1:0] run_q, run_n;

   assign raw = {line_p, line_n};

   generate
      if (SYNC == 0) begin : g_nosync
         assign lvl_raw = raw;
      end else begin : g_sync
         logic [1:0] stg [SYNC];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int k = 0; k < SYNC; k++) stg[k] <= 2'b00;
            end else begin
               stg[0] <= raw;
               for (int k = 1; k < SYNC; k++) stg[k] <= stg[k-1];
            end
         end
         assign lvl_raw = stg[SYNC-1];
      end
   endgenerate

   assign lvl_in = lvl_t'(lvl_raw);

   always_comb begin
      if (lvl_in != lvl_q)      run_n = CW'(1);
      else if (run_q == GAP_K)  run_n = run_q;
      else                      run_n = run_q + CW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q   <= LV_NULL;
         run_q   <= '0;
         bit_stb <= 1'b0;
         bit_val <= 1'b0;
         gap_stb <= 1'b0;
      end else begin
         lvl_q   <= lvl_in;
         run_q   <= run_n;
         bit_stb <= is_data(lvl_in) && (run_n == RUN_K);
         bit_val <= (lvl_in == LV_ONE);
         gap_stb <= (lvl_in == LV_NULL) && (run_n == GAP_K) && (run_q != GAP_K);
      end
   end
endmodule

// File: rtl/rzx_assembler.sv
module rzx_assembler #(
   parameter int WORD_MAX = 32,
   parameter int WORD_MIN = 25
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                len_full,
   input  logic                bit_stb,
   input  logic                bit_val,
   input  logic                gap_stb,
   input  logic                clr_rd,
   output logic                wdone,
   output logic                mid_word,
   output logic [WORD_MAX-2:0] word_q,
   output logic                par_even_q,
   output logic                rdy
);
   localparam int BW = $clog2(WORD_MAX + 1);

   logic [WORD_MAX-1:0] sr, full_n, len_mask;
   logic [WORD_MAX-2:0] data_mask;
   logic [BW-1:0]       bit_cnt, last_idx;

   assign last_idx = len_full ? BW'(WORD_MAX - 1) : BW'(WORD_MIN - 1);

   genvar i;
   generate
      for (i = 0; i < WORD_MAX; i++) begin : g_bits
         assign full_n[i]   = (BW'(i) == bit_cnt) ? bit_val : sr[i];
         assign len_mask[i] = (BW'(i) <= last_idx);
      end
      for (i = 0; i < WORD_MAX - 1; i++) begin : g_data
         assign data_mask[i] = (BW'(i) < last_idx);
      end
   endgenerate

   assign wdone    = bit_stb && (bit_cnt == last_idx);
   assign mid_word = (bit_cnt != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         sr         <= '0;
         bit_cnt    <= '0;
         word_q     <= '0;
         par_even_q <= 1'b0;
         rdy        <= 1'b0;
      end else begin
         if (bit_stb) begin
            sr      <= full_n;
            bit_cnt <= wdone ? '0 : bit_cnt + BW'(1);
         end else if (gap_stb) begin
            bit_cnt <= '0;
         end
         if (wdone) begin
            word_q     <= full_n[WORD_MAX-2:0] & data_mask;
            par_even_q <= ~^(full_n & len_mask);
            rdy        <= 1'b1;
         end else if (clr_rd) begin
            rdy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rzx_busmux.sv
module rzx_busmux #(
   parameter int BUS_W   = 16,
   parameter int PAR_POS = 8
) (
   input  logic                 rd_en,
   input  logic                 half_sel,
   input  logic [2*BUS_W-2:0]   word,
   input  logic                 par_even,
   output logic [BUS_W-1:0]     bus_q
);
   logic [BUS_W-1:0] half0, half1;

   assign half0 = {word[BUS_W-2:PAR_POS], par_even, word[PAR_POS-1:0]};
   assign half1 = word[2*BUS_W-2:BUS_W-1];

   always_comb begin
      if (!rd_en)        bus_q = '0;
      else if (half_sel) bus_q = half1;
      else               bus_q = half0;
   end
endmodule

// File: rtl/rz_word_rx.sv
module rz_word_rx #(
   parameter int OVS      = 10,
   parameter int MIN_RUN  = 3,
   parameter int GAP_BITS = 2,
   parameter int SYNC     = 1,
   parameter int WORD_MAX = 32,
   parameter int WORD_MIN = 25,
   parameter int BUS_W    = 16,
   parameter int PAR_POS  = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ln_pos,
   input  logic             ln_neg,
   input  logic             len_full,
   input  logic             half_sel,
   input  logic             rd_en,
   output logic             rdy,
   output logic [BUS_W-1:0] bus_q
);
   generate
      if (WORD_MAX != 2 * BUS_W) begin : g_chk_w
         $error("WORD_MAX must equal twice BUS_W");
      end
      if (WORD_MIN < 2 || WORD_MIN >= WORD_MAX) begin : g_chk_min
         $error("WORD_MIN must lie between 2 and WORD_MAX-1");
      end
      if (MIN_RUN < 2 || MIN_RUN >= OVS) begin : g_chk_run
         $error("MIN_RUN must lie between 2 and OVS-1");
      end
      if (PAR_POS < 1 || PAR_POS > BUS_W - 2) begin : g_chk_par
         $error("PAR_POS must lie between 1 and BUS_W-2");
      end
      if (SYNC < 0 || GAP_BITS < 1) begin : g_chk_misc
         $error("SYNC must be >= 0 and GAP_BITS >= 1");
      end
   endgenerate

   logic                bit_stb, bit_val, gap_stb;
   logic                wdone, mid_word, par_even;
   logic [WORD_MAX-2:0] word_q;

   rzx_sampler #(
      .OVS(OVS), .MIN_RUN(MIN_RUN), .GAP_BITS(GAP_BITS), .SYNC(SYNC)
   ) u_samp (
      .clk(clk), .rst(rst), .line_p(ln_pos), .line_n(ln_neg),
      .bit_stb(bit_stb), .bit_val(bit_val), .gap_stb(gap_stb)
   );

   rzx_assembler #(
      .WORD_MAX(WORD_MAX), .WORD_MIN(WORD_MIN)
   ) u_asm (
      .clk(clk), .rst(rst), .len_full(len_full),
      .bit_stb(bit_stb), .bit_val(bit_val), .gap_stb(gap_stb),
      .clr_rd(rd_en & half_sel),
      .wdone(wdone), .mid_word(mid_word),
      .word_q(word_q), .par_even_q(par_even), .rdy(rdy)
   );

   rzx_busmux #(
      .BUS_W(BUS_W), .PAR_POS(PAR_POS)
   ) u_mux (
      .rd_en(rd_en), .half_sel(half_sel),
      .word(word_q), .par_even(par_even), .bus_q(bus_q)
   );
endmodule

// File: rtl/rzx_chk.sv
module rzx_chk #(
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             rd_en,
   input logic             half_sel,
   input logic             rdy,
   input logic [BUS_W-1:0] bus_q,
   input logic             wdone,
   input logic             bit_stb,
   input logic             gap_stb,
   input logic             mid_word
);
   // R1: one pulse yields a single bit strobe
   a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
      bit_stb |=> !bit_stb);

   // R6: completed word raises ready
   a_r6_ready_rises: assert property (@(posedge clk) disable iff (rst)
      wdone |=> rdy);

   // R6: ready held without a half-1 read
   a_r6_ready_holds: assert property (@(posedge clk) disable iff (rst)
      (rdy && !(rd_en && half_sel)) |=> rdy);

   // R7: half-1 read clears ready
   a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
      (rd_en && half_sel && !wdone) |=> !rdy);

   // R9: long null empties the partial word
   a_r9_gap_discards: assert property (@(posedge clk) disable iff (rst)
      (gap_stb && !bit_stb) |=> !mid_word);

   // R10: bus idle when not enabled
   a_r10_bus_idle: assert property (@(posedge clk) disable iff (rst)
      !rd_en |-> (bus_q == '0));

   // R11: reset clears ready
   a_r11_reset_clears: assert property (@(posedge clk)
      rst |=> (!rdy && !mid_word));
endmodule

bind rz_word_rx rzx_chk #(.BUS_W(BUS_W)) u_chk (
   .clk(clk), .rst(rst), .rd_en(rd_en), .half_sel(half_sel),
   .rdy(rdy), .bus_q(bus_q), .wdone(wdone), .bit_stb(bit_stb),
   .gap_stb(gap_stb), .mid_word(mid_word)
);

// File: tb/rz_word_rx_tb.sv
module rz_word_rx_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ln_pos = 1'b0, ln_neg = 1'b0;
   logic        len_full = 1'b1, half_sel = 1'b0, rd_en = 1'b0;
   logic        rdy;
   logic [15:0] bus_q;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rz_word_rx u_dut (
      .clk(clk), .rst(rst), .ln_pos(ln_pos), .ln_neg(ln_neg),
      .len_full(len_full), .half_sel(half_sel), .rd_en(rd_en),
      .rdy(rdy), .bus_q(bus_q)
   );

   function automatic logic par_stat(logic [31:0] w, int len);
      int ones = 0;
      for (int k = 0; k < len; k++) ones += w[k];
      return (ones % 2) == 0;
   endfunction

   function automatic logic [31:0] data_of(logic [31:0] w, int len);
      logic [31:0] d = '0;
      for (int k = 0; k < len - 1; k++) d[k] = w[k];
      return d;
   endfunction

   function automatic logic [15:0] exp_h0(logic [31:0] w, int len);
      logic [31:0] d = data_of(w, len);
      return {d[14:8], par_stat(w, len), d[7:0]};
   endfunction

   function automatic logic [15:0] exp_h1(logic [31:0] w, int len);
      logic [31:0] d = data_of(w, len);
      return d[30:15];
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(logic p, logic n, int cyc);
      ln_pos = p;
      ln_neg = n;
      repeat (cyc) @(negedge clk);
   endtask

   task automatic send_bits(logic [31:0] w, int nbits, bit rnd, bit glitch);
      for (int k = 0; k < nbits; k++) begin
         int hi  = rnd ? 3 + int'($urandom % 4) : 5;
         int nul = rnd ? 1 + int'($urandom % 7) : 5;
         drive(w[k], !w[k], hi);
         drive(1'b0, 1'b0, nul);
         if (glitch) begin
            drive(1'b1, 1'b0, 2);
            drive(1'b0, 1'b0, 1);
            drive(1'b0, 1'b1, 2);
            drive(1'b0, 1'b0, 1);
            drive(1'b1, 1'b1, 1);
            drive(1'b0, 1'b0, 2);
         end
      end
      drive(1'b0, 1'b0, 8);
   endtask

   task automatic read_word(string tag, logic [31:0] w, int len);
      check({tag, " rdy before read (R6)"}, 32'(rdy), 32'd1);
      rd_en = 1'b1; half_sel = 1'b0;
      #1 check({tag, " half0 (R2/R5)"}, 32'(bus_q), 32'(exp_h0(w, len)));
      @(negedge clk);
      check({tag, " rdy after half0 read (R7)"}, 32'(rdy), 32'd1);
      half_sel = 1'b1;
      #1 check({tag, " half1 (R2/R3/R4)"}, 32'(bus_q), 32'(exp_h1(w, len)));
      @(negedge clk);
      rd_en = 1'b0; half_sel = 1'b0;
      #1 check({tag, " rdy cleared by half1 read (R7)"}, 32'(rdy), 32'd0);
   endtask

   initial begin
      int unsigned seed_init;
      logic [31:0] w, w2;
      seed_init = $urandom(32'h5A17);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R11: reset state
      check("R11 rdy after reset", 32'(rdy), 32'd0);
      rd_en = 1'b1;
      #1 check("R11 latch empty after reset", 32'(bus_q), 32'd0);
      rd_en = 1'b0;
      @(negedge clk);

      // R5: all zeros, even parity
      len_full = 1'b1;
      send_bits(32'h0, 32, 1'b0, 1'b0);
      read_word("R5 zeros", 32'h0, 32);
      // R5: single one, odd parity
      send_bits(32'h0000_0100, 32, 1'b0, 1'b0);
      read_word("R5 single one", 32'h0000_0100, 32);

      // R10: bus zero while disabled, with a word latched
      w = 32'hFFFF_FFFF;
      send_bits(w, 32, 1'b0, 1'b0);
      #1 check("R10 bus idle with rd_en low", 32'(bus_q), 32'd0);
      read_word("R3 all ones", w, 32);

      // R4: 25-bit mode, ones above the word
      len_full = 1'b0;
      w = 32'hFFFF_FFFF;
      send_bits(w, 25, 1'b0, 1'b0);
      read_word("R4 short all ones", w, 25);

      // R1: random timing over both modes
      for (int n = 0; n < 24; n++) begin
         int len;
         len_full = $urandom % 2;
         len = len_full ? 32 : 25;
         w = $urandom;
         send_bits(w, len, 1'b1, 1'b0);
         read_word("R1 random", w, len);
      end

      // R1: sub-threshold pulses and both-high samples in the nulls
      len_full = 1'b1;
      w = 32'hA5C3_1E69;
      send_bits(w, 32, 1'b0, 1'b1);
      read_word("R1 glitch reject", w, 32);

      // R8: overwrite before read
      w  = 32'h1357_9BDF;
      w2 = 32'h8642_0ECA;
      send_bits(w, 32, 1'b1, 1'b0);
      send_bits(w2, 32, 1'b1, 1'b0);
      read_word("R8 overwrite", w2, 32);

      // R9: partial word, long null, then a full word
      send_bits(32'h0000_03FF, 10, 1'b0, 1'b0);
      drive(1'b0, 1'b0, 30);
      check("R9 no ready from partial", 32'(rdy), 32'd0);
      w = 32'h3C5A_96E1;
      send_bits(w, 32, 1'b1, 1'b0);
      read_word("R9 after discard", w, 32);

      // R11: reset with a word latched and a partial in progress
      w = 32'h7777_0001;
      send_bits(w, 32, 1'b0, 1'b0);
      send_bits(32'h0000_0155, 12, 1'b0, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R11 rdy cleared by reset", 32'(rdy), 32'd0);
      rd_en = 1'b1;
      #1 check("R11 latch cleared by reset", 32'(bus_q), 32'd0);
      rd_en = 1'b0;
      @(negedge clk);
      w = 32'h0F0F_55AA;
      send_bits(w, 32, 1'b0, 1'b0);
      read_word("R11 word after reset", w, 32);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule